// File: doc/BRIEF.md
# Flash Sector Erase Suspend Controller

This block models the command and state logic of a byte-wide parallel flash device. It does so in a behavioural but synthesizable way, and it uses a small register file as the cell array. Bus write cycles carry a command or data byte. Read cycles return either array contents or a status byte. Programming, chip erase, the sector-erase acceptance window, sector erasing and erase suspension are all timed by cycle counters, which stand in for real cell timing.

A sector erase is armed by a setup byte followed by the sector command at any address inside the target sector. An acceptance window runs first, and then the erase itself. A suspend byte written during either phase stops the work:

- In the acceptance window, it parks the erase at once.
- While erasing, it parks the erase after a fixed latency.

While the erase is parked, the host can read the other sectors normally. Writing the resume byte continues the erase from where it stopped. A read is registered, and its result appears on `rd_data` one cycle after the read strobe.

Top module: `sector_erase_ctl`

## Requirements
- R1: After reset every array byte reads FFh, and `rd_data` holds 00h until the first read.
- R2: The byte A0h followed by one data write at an address starts a program operation.
  - The program operation lasts PROG_CYC cycles.
  - During it, every read returns bit 7 = inverse of bit 7 of the data byte, bit 6 = toggle, and bits 5..0 = 0.
  - Afterwards the byte holds the bitwise AND of its old value and the data.
- R3: The byte 80h followed by 30h at an address in a sector starts a sector erase. The sector is the top SECT_W address bits of that address.
  - A TO_CYC-cycle acceptance window runs first, followed by ERASE_CYC cycles of erasing.
  - While busy, every read returns bit 7 = 0, and bit 6 inverts on each successive read.
  - Afterwards that sector reads FFh and the other sectors are unchanged.
- R4: The suspend byte (SUSP_CMD, default B0h) written in the acceptance window enters the suspended state on the next cycle. While suspended, reads in the erasing sector return bit 7 = 1 with bit 6 frozen.
- R5: The suspend byte written while erasing keeps reads at busy status for SUS_CYC cycles, and then enters the suspended state.
- R6: While suspended, reads from any other sector return array data.
- R7: While suspended, every write except 30h is ignored, including further suspend bytes, program bytes and setup bytes.
- R8: 30h written while suspended resumes erasing at any address, with the erase time that was left.
  - A 30h written while erasing is ignored.
  - A new suspend is accepted after resuming.
- R9: The suspend byte has no effect during programming or chip erase.
- R10: The byte 80h followed by 10h erases the whole array in CERASE_CYC cycles, with busy status as in R3. Every byte then reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Command or data byte |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: array byte or status |

## Verification
On every cycle, the assertions check the following:
- A suspend in the acceptance window parks the erase immediately.
- The suspended state holds against every write except resume, and resume returns to erasing.
- The remaining erase time and the toggle bit are frozen while suspended.
- Busy reads carry bit 7 low, and suspended reads in the erasing sector carry it high.
- Suspension is never reached from programming or chip erase.

Only the bench scenarios can show the following:
- The exact durations of each timed phase, including the suspend latency.
- That resumed erasing finishes with the right remaining time.
- That array contents are correct after program, sector erase and chip erase.
- That writes ignored while suspended leave no trace in the array.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_PROG  = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_SETUP = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_CHIP  = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_SECT  = 8'h30;  // also the resume byte

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PARM,
    ST_SETUP,
    ST_PROG,
    ST_CERASE,
    ST_SETO,
    ST_SERUN,
    ST_SUSPG,
    ST_SUSPD
  } fst_e;
endpackage

// File: rtl/sec_cmd_fsm.sv
module sec_cmd_fsm
  import sec_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int SECT_W     = 2,
  parameter int CNT_W      = 5,
  parameter int PROG_CYC   = 4,
  parameter int CERASE_CYC = 12,
  parameter int TO_CYC     = 8,
  parameter int ERASE_CYC  = 20,
  parameter int SUS_CYC    = 3,
  parameter logic [7:0] SUSP_CMD = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output fst_e              st,
  output logic [SECT_W-1:0] sect,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [BYTE_W-1:0] prog_data,
  output logic              prog_do,
  output logic              chip_do,
  output logic              sect_do
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  fst_e              st_q, st_d;
  logic [CNT_W-1:0]  tmr_q, tmr_d, eleft_q, eleft_d;
  logic [SECT_W-1:0] sect_q, sect_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [BYTE_W-1:0] pd_q, pd_d;
  logic              is_susp, is_sect;

  assign is_susp = wr_en && (wr_data == SUSP_CMD);
  assign is_sect = wr_en && (wr_data == CMD_SECT);

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    eleft_d = eleft_q;
    sect_d  = sect_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_en && wr_data == CMD_PROG)       st_d = ST_PARM;
        else if (wr_en && wr_data == CMD_SETUP) st_d = ST_SETUP;
      end
      ST_PARM: if (wr_en) begin
        st_d  = ST_PROG;
        tmr_d = CNT_W'(PROG_CYC);
        pa_d  = wr_addr;
        pd_d  = wr_data;
      end
      ST_SETUP: if (wr_en) begin
        if (wr_data == CMD_CHIP) begin
          st_d  = ST_CERASE;
          tmr_d = CNT_W'(CERASE_CYC);
        end else if (wr_data == CMD_SECT) begin
          st_d   = ST_SETO;
          tmr_d  = CNT_W'(TO_CYC);
          sect_d = wr_addr[ADDR_W-1 -: SECT_W];
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_PROG, ST_CERASE: begin
        if (tmr_q == ONE) st_d = ST_IDLE;
        else              tmr_d = tmr_q - ONE;
      end
      ST_SETO: begin
        if (is_susp) begin
          st_d    = ST_SUSPD;
          eleft_d = CNT_W'(ERASE_CYC);
        end else if (tmr_q == ONE) begin
          st_d    = ST_SERUN;
          eleft_d = CNT_W'(ERASE_CYC);
        end else begin
          tmr_d = tmr_q - ONE;
        end
      end
      ST_SERUN: begin
        if (eleft_q == ONE) begin
          st_d = ST_IDLE;
        end else begin
          eleft_d = eleft_q - ONE;
          if (is_susp) begin
            st_d  = ST_SUSPG;
            tmr_d = CNT_W'(SUS_CYC);
          end
        end
      end
      ST_SUSPG: begin
        if (tmr_q == ONE) st_d = ST_SUSPD;
        else              tmr_d = tmr_q - ONE;
      end
      ST_SUSPD: if (is_sect) st_d = ST_SERUN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      eleft_q <= '0;
      sect_q  <= '0;
      pa_q    <= '0;
      pd_q    <= '0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      eleft_q <= eleft_d;
      sect_q  <= sect_d;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
    end
  end

  assign st        = st_q;
  assign sect      = sect_q;
  assign prog_addr = pa_q;
  assign prog_data = pd_q;
  assign prog_do   = (st_q == ST_PROG)   && (tmr_q == ONE);
  assign chip_do   = (st_q == ST_CERASE) && (tmr_q == ONE);
  assign sect_do   = (st_q == ST_SERUN)  && (eleft_q == ONE);

  AST_TO_SUSPEND_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETO && is_susp) |=> (st_q == ST_SUSPD)); // R4
  AST_RUN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERUN && is_susp && eleft_q != ONE) |=> (st_q == ST_SUSPG)); // R5
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSPD && !is_sect) |=> (st_q == ST_SUSPD)); // R7
  AST_RESUME_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSPD && is_sect) |=> (st_q == ST_SERUN)); // R8
  AST_ELEFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSPD) |=> $stable(eleft_q)); // R8
  AST_NO_SUSP_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROG || st_q == ST_CERASE) |=> (st_q != ST_SUSPG && st_q != ST_SUSPD)); // R9
endmodule

// File: rtl/sec_array.sv
module sec_array
  import sec_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SECT_W-1:0] sect,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [BYTE_W-1:0] prog_data,
  input  logic              prog_do,
  input  logic              chip_do,
  input  logic              sect_do,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*BYTE_W-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [ADDR_W-1:0] A = ADDR_W'(i);
    logic [BYTE_W-1:0] cell_q;
    logic              wipe, pgm;
    assign wipe = chip_do || (sect_do && (A[ADDR_W-1 -: SECT_W] == sect));
    assign pgm  = prog_do && (prog_addr == A);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cell_q <= '1;
      else if (wipe) cell_q <= '1;
      else if (pgm)  cell_q <= cell_q & prog_data;
    end
    assign flat[i*BYTE_W +: BYTE_W] = cell_q;
  end

  assign rd_word = flat[rd_addr*BYTE_W +: BYTE_W];
endmodule

// File: rtl/sec_rd_path.sv
module sec_rd_path
  import sec_pkg::*;
#(
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SECT_W-1:0] rd_sect,
  input  fst_e              st,
  input  logic [SECT_W-1:0] sect,
  input  logic              prog_msb,
  input  logic [BYTE_W-1:0] arr_word,
  output logic [BYTE_W-1:0] rd_data
);
  logic              busy, erase_busy, frozen_hit;
  logic              tgl_q, tgl_d;
  logic [BYTE_W-1:0] rd_q, rd_d;

  assign erase_busy = (st == ST_CERASE) || (st == ST_SETO) ||
                      (st == ST_SERUN)  || (st == ST_SUSPG);
  assign busy       = erase_busy || (st == ST_PROG);
  assign frozen_hit = (st == ST_SUSPD) && (rd_sect == sect);

  always_comb begin
    rd_d  = rd_q;
    tgl_d = tgl_q;
    if (rd_en) begin
      if (busy) begin
        rd_d  = {(st == ST_PROG) ? ~prog_msb : 1'b0, tgl_q, {(BYTE_W-2){1'b0}}};
        tgl_d = ~tgl_q;
      end else if (frozen_hit) begin
        rd_d = {1'b1, tgl_q, {(BYTE_W-2){1'b0}}};
      end else begin
        rd_d = arr_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      tgl_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      tgl_q <= tgl_d;
    end
  end

  assign rd_data = rd_q;

  AST_BUSY_DQ7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && erase_busy) |=> !rd_q[BYTE_W-1]); // R3
  AST_SUSP_DQ7_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && frozen_hit) |=> rd_q[BYTE_W-1]); // R4
  AST_TGL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSPD) |=> $stable(tgl_q)); // R4
endmodule

// File: rtl/sector_erase_ctl.sv
module sector_erase_ctl
  import sec_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int SECT_W     = 2,
  parameter int PROG_CYC   = 4,
  parameter int CERASE_CYC = 12,
  parameter int TO_CYC     = 8,
  parameter int ERASE_CYC  = 20,
  parameter int SUS_CYC    = 3,
  parameter logic [7:0] SUSP_CMD = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int M1    = (PROG_CYC > CERASE_CYC) ? PROG_CYC : CERASE_CYC;
  localparam int M2    = (TO_CYC > ERASE_CYC) ? TO_CYC : ERASE_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > SUS_CYC) ? M3 : SUS_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [1:0]        rsync_q;
  logic              rst_s;
  fst_e              st;
  logic [SECT_W-1:0] sect;
  logic [ADDR_W-1:0] prog_addr;
  logic [BYTE_W-1:0] prog_data, arr_word;
  logic              prog_do, chip_do, sect_do;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  sec_cmd_fsm #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .CERASE_CYC(CERASE_CYC), .TO_CYC(TO_CYC),
    .ERASE_CYC(ERASE_CYC), .SUS_CYC(SUS_CYC), .SUSP_CMD(SUSP_CMD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .st(st), .sect(sect), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_do(prog_do), .chip_do(chip_do),
    .sect_do(sect_do)
  );

  sec_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_s), .sect(sect), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_do(prog_do), .chip_do(chip_do),
    .sect_do(sect_do), .rd_addr(rd_addr), .rd_word(arr_word)
  );

  sec_rd_path #(.SECT_W(SECT_W)) u_rd (
    .clk(clk), .rst_n(rst_s), .rd_en(rd_en),
    .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]), .st(st), .sect(sect),
    .prog_msb(prog_data[BYTE_W-1]), .arr_word(arr_word), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_sector_erase_ctl.sv
module tb_sector_erase_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int P_PROG = 4, P_CER = 12, P_TO = 8, P_ER = 20, P_SUS = 3;

  localparam int M_IDLE = 0, M_PARM = 1, M_SETUP = 2, M_PROG = 3, M_CER = 4,
                 M_SETO = 5, M_RUN = 6, M_SUSG = 7, M_SUSD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  logic [7:0] b6;

  sector_erase_ctl #(
    .ADDR_W(AW), .SECT_W(2), .PROG_CYC(P_PROG), .CERASE_CYC(P_CER),
    .TO_CYC(P_TO), .ERASE_CYC(P_ER), .SUS_CYC(P_SUS), .SUSP_CMD(8'hB0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_st, m_tmr, m_left, m_sect, m_pa, m_tg;
  logic [7:0] m_pd;
  logic [7:0] m_mem [32];
  logic [7:0] exp_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_tmr = 0; m_left = 0; m_sect = 0; m_pa = 0; m_pd = 0;
      m_tg = 0; exp_rd = 8'h00;
      for (int i = 0; i < 32; i++) m_mem[i] = 8'hFF;
    end else begin
      if (rd_en) begin
        if (m_st == M_PROG || m_st == M_CER || m_st == M_SETO ||
            m_st == M_RUN || m_st == M_SUSG) begin
          exp_rd = {(m_st == M_PROG) ? ~m_pd[7] : 1'b0, m_tg[0], 6'b0};
          m_tg = 1 - m_tg;
        end else if (m_st == M_SUSD && (int'(rd_addr) / 8) == m_sect)
          exp_rd = {1'b1, m_tg[0], 6'b0};
        else
          exp_rd = m_mem[rd_addr];
      end
      case (m_st)
        M_IDLE: if (wr_en && wr_data == 8'hA0) m_st = M_PARM;
                else if (wr_en && wr_data == 8'h80) m_st = M_SETUP;
        M_PARM: if (wr_en) begin
          m_st = M_PROG; m_tmr = P_PROG; m_pa = int'(wr_addr); m_pd = wr_data;
        end
        M_SETUP: if (wr_en) begin
          if (wr_data == 8'h10) begin m_st = M_CER; m_tmr = P_CER; end
          else if (wr_data == 8'h30) begin
            m_st = M_SETO; m_tmr = P_TO; m_sect = int'(wr_addr) / 8;
          end else m_st = M_IDLE;
        end
        M_PROG: begin
          m_tmr--;
          if (m_tmr == 0) begin m_mem[m_pa] = m_mem[m_pa] & m_pd; m_st = M_IDLE; end
        end
        M_CER: begin
          m_tmr--;
          if (m_tmr == 0) begin
            for (int i = 0; i < 32; i++) m_mem[i] = 8'hFF;
            m_st = M_IDLE;
          end
        end
        M_SETO: begin
          if (wr_en && wr_data == 8'hB0) begin m_st = M_SUSD; m_left = P_ER; end
          else begin
            m_tmr--;
            if (m_tmr == 0) begin m_st = M_RUN; m_left = P_ER; end
          end
        end
        M_RUN: begin
          m_left--;
          if (m_left == 0) begin
            for (int i = 0; i < 8; i++) m_mem[m_sect*8 + i] = 8'hFF;
            m_st = M_IDLE;
          end else if (wr_en && wr_data == 8'hB0) begin
            m_st = M_SUSG; m_tmr = P_SUS;
          end
        end
        M_SUSG: begin
          m_tmr--;
          if (m_tmr == 0) m_st = M_SUSD;
        end
        M_SUSD: if (wr_en && wr_data == 8'h30) m_st = M_RUN;
        default: m_st = M_IDLE;
      endcase
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL %s model compare: actual=%h expected=%h", cur_req, rd_data, exp_rd);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic cyc(bit we, int wa, int wd, bit re, int ra);
    wr_en = we; wr_addr = AW'(wa); wr_data = 8'(wd);
    rd_en = re; rd_addr = AW'(ra);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(int a, int d); cyc(1'b1, a, d, 1'b0, 0); endtask
  task automatic rd(int a); cyc(1'b0, 0, 0, 1'b1, a); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0, 0); endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, logic [7:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h mask=%h", tag, act, exp, mask);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R1";
    chk("R1 reset rd_data", rd_data, 8'h00, 8'hFF);
    rd(0);  chk("R1 erased byte 0", rd_data, 8'hFF, 8'hFF);
    rd(31); chk("R1 erased byte 31", rd_data, 8'hFF, 8'hFF);

    cur_req = "R2";
    wr(0, 'hA0); wr(3, 'h5A);
    rd(3); chk("R2 program DQ7 inverse", rd_data, 8'h80, 8'hC0 & 8'h80);
    b6 = rd_data;
    rd(3); chk("R2 program DQ6 toggles", rd_data, ~b6, 8'h40);
    cur_req = "R9";
    wr(0, 'hB0);
    rd(3); chk("R9 suspend ignored in program", rd_data, 8'h80, 8'h80);
    idle(3);
    cur_req = "R2";
    rd(3); chk("R2 programmed byte", rd_data, 8'h5A, 8'hFF);
    wr(0, 'hA0); wr(3, 'h0F); idle(6);
    rd(3); chk("R2 program ANDs old value", rd_data, 8'h0A, 8'hFF);
    wr(0, 'hA0); wr(12, 'h3C); idle(6);
    rd(12); chk("R2 programmed byte 12", rd_data, 8'h3C, 8'hFF);

    cur_req = "R3";
    wr(0, 'h80); wr(2, 'h30);
    rd(0); chk("R3 window DQ7 low", rd_data, 8'h00, 8'h80);
    b6 = rd_data;
    rd(5); chk("R3 window DQ6 toggles", rd_data, ~b6, 8'h40);
    cur_req = "R4";
    wr(9, 'hB0);
    rd(1); chk("R4 suspended DQ7 high", rd_data, 8'h80, 8'h80);
    b6 = rd_data;
    rd(1); chk("R4 suspended DQ6 frozen", rd_data, b6, 8'h40);
    cur_req = "R6";
    rd(12); chk("R6 other sector data", rd_data, 8'h3C, 8'hFF);
    cur_req = "R7";
    wr(0, 'hA0); wr(12, 'h00); wr(0, 'h80); wr(0, 'hB0);
    rd(12); chk("R7 program while suspended ignored", rd_data, 8'h3C, 8'hFF);
    rd(0);  chk("R7 still suspended", rd_data, 8'h80, 8'h80);
    cur_req = "R8";
    wr(31, 'h30);
    rd(0); chk("R8 resume erasing", rd_data, 8'h00, 8'h80);
    wr(0, 'h30);
    rd(0); chk("R8 repeat resume ignored", rd_data, 8'h00, 8'h80);
    cur_req = "R5";
    wr(0, 'hB0);
    rd(0); chk("R5 busy during suspend latency", rd_data, 8'h00, 8'h80);
    idle(3);
    rd(0); chk("R5 suspended after latency", rd_data, 8'h80, 8'h80);
    cur_req = "R8";
    wr(7, 'h30); idle(30);
    cur_req = "R3";
    rd(3);  chk("R3 sector erased", rd_data, 8'hFF, 8'hFF);
    rd(12); chk("R3 other sector kept", rd_data, 8'h3C, 8'hFF);

    cur_req = "R10";
    wr(0, 'hA0); wr(20, 'h11); idle(6);
    rd(20); chk("R10 byte before chip erase", rd_data, 8'h11, 8'hFF);
    wr(0, 'h80); wr(0, 'h10);
    cur_req = "R9";
    wr(0, 'hB0);
    rd(20); chk("R9 suspend ignored in chip erase", rd_data, 8'h00, 8'h80);
    idle(14);
    cur_req = "R10";
    rd(20); chk("R10 chip erased byte 20", rd_data, 8'hFF, 8'hFF);
    rd(12); chk("R10 chip erased byte 12", rd_data, 8'hFF, 8'hFF);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule